// File: doc/BRIEF.md
# Operand-to-Port Bus Cycle Splitter

This block sits between a core's load/store path and an external bus whose ports may be 8, 16 or 32 bits wide. It takes one operand request: an address, a size (byte, word or long word), a direction and, for writes, the data. It then runs as many bus cycles as the port needs to move the whole operand. The port width is not known in advance. The slave reports it with a two-bit active-low termination code at the end of every cycle, and the block uses that width to decide how many bytes the cycle took.

After each termination the block advances the address by the bytes taken. It lowers the size code to the count that is still outstanding. On reads it steers the returned bytes out of the lanes that the port used and into their places in a big-endian operand. On writes it places the next outgoing bytes so that whichever port answers finds them on its own lanes. When the last byte has moved it pulses `done_o`, and for reads it presents the assembled operand right-justified on `rdata_o`.

Top module: `dbs_seq`

## Requirements
- R1: A byte operand (request size code 01) completes after one terminated bus cycle at any address offset and on any port width.
- R2: A word operand (size code 10) takes, for a 32/16/8-bit port, this many terminated cycles: offset 0: 1/1/2; offset 1: 1/2/2; offset 2: 1/1/2; offset 3: 2/2/2.
- R3: A long-word operand (size code 00) takes, for a 32/16/8-bit port, this many terminated cycles: offset 0: 1/2/4; offset 1: 2/3/4; offset 2: 2/2/4; offset 3: 2/3/4.
- R4: The termination code `ack_ni` reads as follows: 00 means a 32-bit port, 01 means a 16-bit port, 10 means an 8-bit port and 11 means no termination. While the code is 11, the active cycle keeps its address and size code and no bytes are taken.
- R5: The first cycle starts in the clock after the request is accepted, at the request address. A terminated cycle takes min(remaining, 4 - addr[1:0]) bytes on a 32-bit port, min(remaining, 2 - addr[0]) on a 16-bit port and 1 on an 8-bit port. The next cycle's address is the current address plus the bytes taken.
- R6: `bus_size_o` always equals the count of bytes still outstanding: 01 = 1, 10 = 2, 11 = 3, 00 = 4.
- R7: Byte lanes are numbered 0 to 3 from bits 31:24 down to bits 7:0. A 32-bit port uses lanes addr[1:0] and upward, a 16-bit port uses lanes addr[0] and upward within lanes 0 and 1, and an 8-bit port uses lane 0. On a write, every lane that the answering port uses carries the matching next operand byte.
- R8: On a read, bytes are collected from the lanes given in R7, and the operand is assembled big-endian (lowest address is most significant), right-justified on `rdata_o`.
- R9: A request with size code 11 is ignored, and no bus cycle starts.
- R10: A request raised while an operand is in progress is ignored. No further cycle follows the current operand's last one.
- R11: `done_o` is high for exactly the one clock after the final termination, and `bus_cyc_o` is low from that clock on. `rdata_o` holds the read operand from then until the next read completes.
- R12: Write data `req_wdata_i` is right-justified and big-endian, so memory at the operand's lowest address receives the most significant byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Operand request, taken when idle |
| req_addr_i | input | ADDR_W | Operand byte address |
| req_size_i | input | 2 | Operand size: 01 byte, 10 word, 00 long word |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | 32 | Write operand, right-justified |
| bus_cyc_o | output | 1 | A bus cycle is in progress |
| bus_addr_o | output | ADDR_W | Address of the current cycle |
| bus_size_o | output | 2 | Outstanding byte count code |
| bus_write_o | output | 1 | Direction of the current cycle |
| bus_wdata_o | output | 32 | Lane-steered write data |
| ack_ni | input | 2 | Active-low termination code giving port width |
| bus_rdata_i | input | 32 | Read data lanes from the slave |
| done_o | output | 1 | One-clock pulse when the operand is complete |
| rdata_o | output | 32 | Assembled read operand, right-justified |

## Verification
Every operand size is tried at all four address offsets, against 32-, 16- and 8-bit ports, in both directions. This set of patterns separates the per-port take rules. For example, a long word at offset 1 takes three cycles on a 16-bit port but two on a 32-bit one, and a word at offset 1 shows the difference between the 16-bit rule and the 32-bit rule. Runs with wait states show that an unterminated cycle moves nothing. Requests with an illegal size, and requests raised mid-operand, check that the block ignores them.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LANES  = 4;
  localparam int unsigned DATA_W = BYTE_W * LANES;
  localparam int unsigned CNT_W  = $clog2(LANES) + 1;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef byte_t [LANES-1:0] opbuf_t;  // element i = operand byte i (i = 0 lowest address)

  typedef enum logic [1:0] {
    PW_32   = 2'd0,
    PW_16   = 2'd1,
    PW_8    = 2'd2,
    PW_WAIT = 2'd3
  } port_e;

  function automatic port_e ack_decode(input logic [1:0] ack_n);
    unique case (ack_n)
      2'b00:   return PW_32;
      2'b01:   return PW_16;
      2'b10:   return PW_8;
      default: return PW_WAIT;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] size_bytes(input logic [1:0] sz);
    unique case (sz)
      2'b01:   return CNT_W'(1);
      2'b10:   return CNT_W'(2);
      2'b00:   return CNT_W'(LANES);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/dbs_step.sv
module dbs_step
  import dbs_pkg::*;
(
  input  port_e            port_i,
  input  logic [1:0]       off_i,
  input  logic [CNT_W-1:0] rem_i,
  output logic [CNT_W-1:0] take_o
);
  logic [CNT_W-1:0] room;

  always_comb begin
    unique case (port_i)
      PW_32:   room = CNT_W'(LANES) - CNT_W'(off_i);
      PW_16:   room = CNT_W'(2) - CNT_W'(off_i[0]);
      PW_8:    room = CNT_W'(1);
      default: room = '0;
    endcase
    take_o = (rem_i < room) ? rem_i : room;
  end
endmodule

// File: rtl/dbs_wr_lanes.sv
module dbs_wr_lanes
  import dbs_pkg::*;
(
  input  opbuf_t            buf_i,
  input  logic [CNT_W-1:0]  idx_i,
  input  logic [1:0]        off_i,
  output logic [DATA_W-1:0] data_o
);
  // Upper two lanes follow the 16-bit view, lower two the 32-bit view; unused lanes repeat the next byte.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [CNT_W-1:0] sel;
    if (l < 2) begin : g_hi
      assign sel = ({1'b0, off_i[0]} <= 2'(l)) ? idx_i + CNT_W'(l) - CNT_W'(off_i[0]) : idx_i;
    end else begin : g_lo
      assign sel = (off_i <= 2'(l)) ? idx_i + CNT_W'(l) - CNT_W'(off_i) : idx_i;
    end
    assign data_o[DATA_W-1-BYTE_W*l -: BYTE_W] = (sel < CNT_W'(LANES)) ? buf_i[sel[1:0]] : '0;
  end
endmodule

// File: rtl/dbs_rd_merge.sv
module dbs_rd_merge
  import dbs_pkg::*;
(
  input  opbuf_t            buf_i,
  input  logic [DATA_W-1:0] data_i,
  input  port_e             port_i,
  input  logic [1:0]        off_i,
  input  logic [CNT_W-1:0]  idx_i,
  input  logic [CNT_W-1:0]  take_i,
  output opbuf_t            buf_o
);
  byte_t [LANES-1:0] lane_b;

  for (genvar l = 0; l < LANES; l++) begin : g_split
    assign lane_b[l] = data_i[DATA_W-1-BYTE_W*l -: BYTE_W];
  end

  for (genvar i = 0; i < LANES; i++) begin : g_byte
    logic [CNT_W-1:0] rel;
    logic             hit;
    logic [1:0]       lane;
    assign rel = CNT_W'(i) - idx_i;
    assign hit = (CNT_W'(i) >= idx_i) && (rel < take_i);
    always_comb begin
      unique case (port_i)
        PW_32:   lane = off_i + rel[1:0];
        PW_16:   lane = {1'b0, off_i[0]} + rel[1:0];
        default: lane = 2'd0;
      endcase
    end
    assign buf_o[i] = hit ? lane_b[lane] : buf_i[i];
  end
endmodule

// File: rtl/dbs_seq.sv
module dbs_seq
  import dbs_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic              req_write_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              bus_cyc_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [1:0]        bus_size_o,
  output logic              bus_write_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [1:0]        ack_ni,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned SH_W = CNT_W + $clog2(BYTE_W);

  logic              active_q, write_q, done_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  rem_q, idx_q, n_q;
  opbuf_t            buf_q, merged, load_buf;
  logic [DATA_W-1:0] rdata_q, wlanes;

  port_e            port;
  logic [CNT_W-1:0] req_n, take;
  logic             start, term, last;

  assign port  = ack_decode(ack_ni);
  assign req_n = size_bytes(req_size_i);
  assign start = req_i && !active_q && (req_n != '0);
  assign term  = active_q && (port != PW_WAIT);
  assign last  = term && (take == rem_q);

  // Left-justify the write operand so byte 0 is the most significant.
  logic [SH_W-1:0]   ld_sh, rd_sh;
  logic [DATA_W-1:0] ld_lj, rd_lj, rd_packed;
  assign ld_sh = {CNT_W'(LANES) - req_n, 3'b000};
  assign ld_lj = req_wdata_i << ld_sh;
  assign rd_sh = {CNT_W'(LANES) - n_q, 3'b000};

  for (genvar i = 0; i < LANES; i++) begin : g_pack
    assign load_buf[i] = ld_lj[DATA_W-1-BYTE_W*i -: BYTE_W];
    assign rd_lj[DATA_W-1-BYTE_W*i -: BYTE_W] = merged[i];
  end
  assign rd_packed = rd_lj >> rd_sh;

  dbs_step u_step (
    .port_i (port),
    .off_i  (addr_q[1:0]),
    .rem_i  (rem_q),
    .take_o (take)
  );

  dbs_wr_lanes u_wr (
    .buf_i  (buf_q),
    .idx_i  (idx_q),
    .off_i  (addr_q[1:0]),
    .data_o (wlanes)
  );

  dbs_rd_merge u_rd (
    .buf_i  (buf_q),
    .data_i (bus_rdata_i),
    .port_i (port),
    .off_i  (addr_q[1:0]),
    .idx_i  (idx_q),
    .take_i (take),
    .buf_o  (merged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      write_q  <= 1'b0;
      done_q   <= 1'b0;
      addr_q   <= '0;
      rem_q    <= '0;
      idx_q    <= '0;
      n_q      <= '0;
      buf_q    <= '0;
      rdata_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        active_q <= 1'b1;
        write_q  <= req_write_i;
        addr_q   <= req_addr_i;
        rem_q    <= req_n;
        idx_q    <= '0;
        n_q      <= req_n;
        buf_q    <= req_write_i ? load_buf : '0;
      end else if (term) begin
        addr_q <= addr_q + ADDR_W'(take);
        rem_q  <= rem_q - take;
        idx_q  <= idx_q + take;
        if (!write_q) buf_q <= merged;
        if (last) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
          if (!write_q) rdata_q <= rd_packed;
        end
      end
    end
  end

  assign bus_cyc_o   = active_q;
  assign bus_addr_o  = addr_q;
  assign bus_size_o  = rem_q[1:0];
  assign bus_write_o = write_q;
  assign bus_wdata_o = write_q ? wlanes : '0;
  assign done_o      = done_q;
  assign rdata_o     = rdata_q;
endmodule

// File: rtl/dbs_seq_chk.sv
module dbs_seq_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [1:0]        req_size_i,
  input logic              bus_cyc_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [1:0]        bus_size_o,
  input logic              bus_write_o,
  input logic [1:0]        ack_ni,
  input logic              done_o
);
  a_r1_byte_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_cyc_o && bus_size_o == 2'b01 && ack_ni != 2'b11 |=> done_o && !bus_cyc_o);

  a_r4_wait_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_cyc_o && ack_ni == 2'b11 |=> bus_cyc_o && $stable(bus_addr_o) && $stable(bus_size_o));

  a_r5_addr_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_cyc_o && ack_ni != 2'b11 |=> done_o || (bus_cyc_o && bus_addr_o != $past(bus_addr_o)));

  a_r9_bad_size: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_cyc_o && req_i && req_size_i == 2'b11 |=> !bus_cyc_o);

  a_r10_dir_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_cyc_o |=> !bus_cyc_o || $stable(bus_write_o));

  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r11_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !bus_cyc_o);
endmodule

bind dbs_seq dbs_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .req_size_i  (req_size_i),
  .bus_cyc_o   (bus_cyc_o),
  .bus_addr_o  (bus_addr_o),
  .bus_size_o  (bus_size_o),
  .bus_write_o (bus_write_o),
  .ack_ni      (ack_ni),
  .done_o      (done_o)
);

// File: tb/dbs_seq_tb.sv
module dbs_seq_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic [1:0]  req_size_i = 2'b01;
  logic        req_write_i = 1'b0;
  logic [31:0] req_wdata_i = '0;
  logic        bus_cyc_o, bus_write_o, done_o;
  logic [31:0] bus_addr_o, bus_wdata_o, rdata_o;
  logic [1:0]  bus_size_o;
  logic [1:0]  ack_ni = 2'b11;
  logic [31:0] bus_rdata_i = '0;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] mem [16];

  always #10 clk_i = ~clk_i;

  dbs_seq u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .req_addr_i(req_addr_i),
    .req_size_i(req_size_i), .req_write_i(req_write_i), .req_wdata_i(req_wdata_i),
    .bus_cyc_o(bus_cyc_o), .bus_addr_o(bus_addr_o), .bus_size_o(bus_size_o),
    .bus_write_o(bus_write_o), .bus_wdata_o(bus_wdata_o), .ack_ni(ack_ni),
    .bus_rdata_i(bus_rdata_i), .done_o(done_o), .rdata_o(rdata_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_cycles(input int n, input int off, input int port);
    if (n == 1) return 1;
    if (n == 2) begin
      case (off)
        0: return (port == 2) ? 2 : 1;
        1: return (port == 0) ? 1 : 2;
        2: return (port == 2) ? 2 : 1;
        default: return 2;
      endcase
    end
    case (off)
      0: return (port == 0) ? 1 : (port == 1) ? 2 : 4;
      1: return (port == 0) ? 2 : (port == 1) ? 3 : 4;
      2: return (port == 2) ? 4 : 2;
      default: return (port == 0) ? 2 : (port == 1) ? 3 : 4;
    endcase
  endfunction

  // Lane used by a port for byte j of the cycle at offset off (R7).
  function automatic int port_lane(input int port, input logic [1:0] off, input int j);
    if (port == 0) return int'(off) + j;
    if (port == 1) return int'(off[0]) + j;
    return 0;
  endfunction

  task automatic run_op(input logic [31:0] addr, input logic [1:0] size, input bit wr,
                        input logic [31:0] wd, input int port, input int waits, input bit poke);
    int n, rem, k, cyc, take, room, ln;
    logic [31:0] ea, exp_val, got;
    logic [7:0] opb [4];
    string sreq;
    n = (size == 2'b01) ? 1 : (size == 2'b10) ? 2 : 4;
    sreq = (n == 1) ? "R1" : (n == 2) ? "R2" : "R3";
    for (int i = 0; i < 16; i++) mem[i] = wr ? (8'h5A ^ 8'(i)) : (8'hC0 + 8'(i * 7));
    exp_val = '0;
    for (int i = 0; i < n; i++) begin
      opb[i] = wd[8*(n-1-i) +: 8];
      exp_val = (exp_val << 8) | 32'(mem[4'(addr[3:0] + 4'(i))]);
    end
    @(negedge clk_i);
    req_i = 1'b1; req_addr_i = addr; req_size_i = size; req_write_i = wr; req_wdata_i = wd;
    @(negedge clk_i);
    req_i = 1'b0;
    rem = n; k = 0; cyc = 0; ea = addr;
    while (rem > 0 && cyc < 8) begin
      chk(bus_cyc_o, "R5", "cycle active", 32'(bus_cyc_o), 1);
      if (!bus_cyc_o) break;
      chk(bus_addr_o == ea, "R5", "cycle address", bus_addr_o, ea);
      chk(bus_size_o == 2'(rem), "R6", "size code", 32'(bus_size_o), 32'(2'(rem)));
      for (int w = 0; w < waits; w++) begin
        ack_ni = 2'b11;
        if (poke && w == 0) begin
          req_i = 1'b1; req_addr_i = 32'h0000_0080; req_size_i = 2'b00; req_write_i = ~wr;
        end
        @(negedge clk_i);
        req_i = 1'b0;
        chk(bus_cyc_o && bus_addr_o == ea && bus_size_o == 2'(rem), "R4", "wait holds cycle",
            bus_addr_o, ea);
      end
      room = (port == 0) ? 4 - int'(ea[1:0]) : (port == 1) ? 2 - int'(ea[0]) : 1;
      take = (rem < room) ? rem : room;
      ack_ni = (port == 0) ? 2'b00 : (port == 1) ? 2'b01 : 2'b10;
      bus_rdata_i = '0;
      for (int j = 0; j < take; j++) begin
        ln = port_lane(port, ea[1:0], j);
        if (wr) begin
          got = 32'(bus_wdata_o[31-8*ln -: 8]);
          chk(got == 32'(opb[k+j]), "R7", "write lane byte", got, 32'(opb[k+j]));
          mem[4'(ea[3:0] + 4'(j))] = bus_wdata_o[31-8*ln -: 8];
        end else begin
          bus_rdata_i[31-8*ln -: 8] = mem[4'(ea[3:0] + 4'(j))];
        end
      end
      @(negedge clk_i);
      ack_ni = 2'b11; bus_rdata_i = '0;
      cyc++; rem -= take; k += take; ea += 32'(take);
      if (rem == 0) chk(done_o && !bus_cyc_o, "R11", "done at end", 32'({done_o, bus_cyc_o}), 32'b10);
      else chk(!done_o, "R11", "no early done", 32'(done_o), 0);
    end
    chk(cyc == exp_cycles(n, int'(addr[1:0]), port), sreq, "cycle count", 32'(cyc),
        32'(exp_cycles(n, int'(addr[1:0]), port)));
    if (wr) begin
      got = '0;
      for (int i = 0; i < n; i++) got = (got << 8) | 32'(mem[4'(addr[3:0] + 4'(i))]);
      chk(got == (wd & ((n == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8*n)) - 1))), "R12",
          "memory after write", got, wd);
    end else begin
      chk(rdata_o == exp_val, "R8", "read operand", rdata_o, exp_val);
    end
    @(negedge clk_i);
    chk(!done_o && !bus_cyc_o, poke ? "R10" : "R11", "idle after operand",
        32'({done_o, bus_cyc_o}), 0);
  endtask

  task automatic test_bad_size();
    @(negedge clk_i);
    req_i = 1'b1; req_size_i = 2'b11; req_addr_i = 32'h40; req_write_i = 1'b0;
    @(negedge clk_i);
    req_i = 1'b0;
    chk(!bus_cyc_o, "R9", "illegal size ignored", 32'(bus_cyc_o), 0);
    @(negedge clk_i);
    chk(!bus_cyc_o && !done_o, "R9", "still idle", 32'({bus_cyc_o, done_o}), 0);
  endtask

  task automatic test_sweep();
    logic [1:0] sizes [3];
    sizes[0] = 2'b01; sizes[1] = 2'b10; sizes[2] = 2'b00;
    for (int s = 0; s < 3; s++)
      for (int off = 0; off < 4; off++)
        for (int p = 0; p < 3; p++)
          for (int wr = 0; wr < 2; wr++)
            run_op(32'h0000_0040 + 32'(off), sizes[s], wr[0], 32'h8C3E_71D5 ^ 32'(off * 16 + p),
                   p, 0, 1'b0);
  endtask

  task automatic test_waits();
    run_op(32'h0000_0041, 2'b00, 1'b0, '0, 1, 2, 1'b0);
    run_op(32'h0000_0043, 2'b10, 1'b1, 32'h0000_ABCD, 2, 3, 1'b0);
    run_op(32'h0000_0042, 2'b00, 1'b1, 32'h1234_5678, 0, 1, 1'b0);
  endtask

  task automatic test_busy_req();
    run_op(32'h0000_0041, 2'b00, 1'b1, 32'hDEAD_BEEF, 1, 1, 1'b1);
    run_op(32'h0000_0043, 2'b10, 1'b0, '0, 0, 2, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!bus_cyc_o && !done_o && rdata_o == '0, "R11", "reset state",
        32'({bus_cyc_o, done_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!bus_cyc_o, "R9", "idle after reset", 32'(bus_cyc_o), 0);
    test_bad_size();
    test_sweep();
    test_waits();
    test_busy_req();
    test_bad_size();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule